// File: doc/BRIEF.md
# Real-Time Clock Output Control Register

This block is one control register of a real-time clock's register file. It holds two software-controlled fields that choose what a multipurpose open-drain output pin does. It also holds a sticky power-failure flag that hardware raises on every power-on reset. The pin either sits at a static level chosen by software or carries a 512 Hz square wave. The wave comes from a free-running divide-by-64 of a 32.768 kHz timebase, which reaches the block as a single-cycle enable strobe `tick_i` in the system clock domain.

Software reads the register through a combinational read port addressed by byte. It writes through a one-cycle write strobe carrying a byte address and a data byte. The pin is modelled as a drive-low enable: 1 pulls the line low and 0 releases it to the external pull-up. The power-failure flag cannot be written. Hardware sets it, and any write anywhere in the clock section clears it.

Top module: `rtc_outctl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the register holds its defaults: level bit 1, wave enable 0, power-fail flag 1. Reading address 07h returns 8'h81 and `pin_pull_low_o` is 0.
- R2: A read at address 07h returns the level bit in bit 7, the wave enable in bit 6 and the power-fail flag in bit 0. A read at any other address returns 8'h00.
- R3: Bits 5 down to 1 of the register always read 0, whatever data was written to them.
- R4: The power-fail flag cannot be set from the bus. Writing 1 to bit 0 of address 07h leaves a cleared flag at 0. Only `rst` raises it.
- R5: A write to any address from 00h to 07h clears the power-fail flag on the next cycle. A write to 08h or above leaves the flag unchanged.
- R6: A write to address 07h loads bit 7 into the level bit and bit 6 into the wave enable. Both are visible on the read port and at the pin one cycle after the strobe. Writes to other addresses leave both fields unchanged.
- R7: With the wave enable at 0, `pin_pull_low_o` is the inverse of the level bit: level 1 releases the pin and level 0 pulls it low.
- R8: With the wave enable at 1, the pin carries a 50% square wave whatever the level bit. It pulls low while the count of timebase strobes since reset, modulo 64, is 0 to 31, and releases while the count is 32 to 63.
- R9: The divider runs freely from reset on every `tick_i`. Register writes and changes of the wave enable do not reset or disturb its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 1 | One-cycle strobe at 32.768 kHz timebase rate |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Byte address of the write |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 8 | Byte address of the read |
| rd_data_o | output | 8 | Read data, combinational from `rd_addr_i` |
| pin_pull_low_o | output | 1 | Open-drain enable for the output pin, 1 pulls low |
| pwr_fail_o | output | 1 | Power-failure flag |

## Verification
Most wrong internal state shows up at the ports on the cycle after the write or strobe that caused it. A stuck or wrongly cleared power-fail flag shows on `pwr_fail_o` and in bit 0 of the read word one cycle after the offending write. A mis-stored level or enable bit shows on the read port and the pin in that same cycle. A divider with the wrong ratio, phase or reset behaviour is different: it shows only as the wave edges falling on the wrong strobe count, so a fault can stay hidden for up to 32 strobes. The bench therefore follows the pin across more than two full wave periods and across writes made mid-period.

// File: rtl/rtc_outctl_pkg.sv
package rtc_outctl_pkg;

    localparam int unsigned REG_W       = 8;
    localparam int unsigned BIT_LEVEL   = 7;
    localparam int unsigned BIT_WAVE_EN = 6;
    localparam int unsigned BIT_PFAIL   = 0;

    typedef struct packed {
        logic level;
        logic wave_en;
        logic pwr_fail;
    } ctl_t;

    typedef enum logic {
        SRC_LEVEL = 1'b0,
        SRC_WAVE  = 1'b1
    } pin_src_e;

    localparam ctl_t CTL_DEFAULT = '{level: 1'b1, wave_en: 1'b0, pwr_fail: 1'b1};

    function automatic logic [REG_W-1:0] ctl_to_word(input ctl_t c);
        logic [REG_W-1:0] w;
        w              = '0;
        w[BIT_LEVEL]   = c.level;
        w[BIT_WAVE_EN] = c.wave_en;
        w[BIT_PFAIL]   = c.pwr_fail;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] live_mask();
        logic [REG_W-1:0] m;
        m              = '0;
        m[BIT_LEVEL]   = 1'b1;
        m[BIT_WAVE_EN] = 1'b1;
        m[BIT_PFAIL]   = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/rtc_outctl_div.sv
module rtc_outctl_div #(
    parameter int unsigned DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic wave_o
);
    localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned HALF  = DIV / 2;
    localparam logic [CNT_W-1:0] LAST   = CNT_W'(DIV - 1);
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    // High during the second half of each period.
    assign wave_o = (cnt_q >= HALF_C);

endmodule

// File: rtl/rtc_outctl_reg.sv
module rtc_outctl_reg
    import rtc_outctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 7,
    parameter int unsigned SECT_LO  = 0,
    parameter int unsigned SECT_HI  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output ctl_t              ctl_o
);
    localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);
    localparam logic [ADDR_W-1:0] LO_A  = ADDR_W'(SECT_LO);
    localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(SECT_HI);

    ctl_t ctl_q;
    logic hit_reg;
    logic hit_sect;

    assign hit_reg = wr_en_i && (wr_addr_i == REG_A);

    generate
        if (SECT_LO == 0) begin : g_sect_from_zero
            assign hit_sect = wr_en_i && (wr_addr_i <= HI_A);
        end else begin : g_sect_window
            assign hit_sect = wr_en_i && (wr_addr_i >= LO_A) && (wr_addr_i <= HI_A);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_DEFAULT;
        end else begin
            if (hit_reg) begin
                ctl_q.level   <= wr_data_i[BIT_LEVEL];
                ctl_q.wave_en <= wr_data_i[BIT_WAVE_EN];
            end
            if (hit_sect) ctl_q.pwr_fail <= 1'b0;
        end
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/rtc_outctl_pinmux.sv
module rtc_outctl_pinmux
    import rtc_outctl_pkg::*;
(
    input  ctl_t ctl_i,
    input  logic wave_i,
    output logic pull_low_o
);
    pin_src_e src;

    assign src = ctl_i.wave_en ? SRC_WAVE : SRC_LEVEL;

    always_comb begin
        unique case (src)
            SRC_WAVE:  pull_low_o = ~wave_i;
            default:   pull_low_o = ~ctl_i.level;
        endcase
    end

endmodule

// File: rtl/rtc_outctl.sv
module rtc_outctl
    import rtc_outctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 7,
    parameter int unsigned SECT_LO  = 0,
    parameter int unsigned SECT_HI  = 7,
    parameter int unsigned DIV      = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              pin_pull_low_o,
    output logic              pwr_fail_o
);
    localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);
    localparam logic [REG_W-1:0]  LIVE  = live_mask();

    ctl_t             ctl;
    logic             wave;
    logic [REG_W-1:0] word;
    logic             ft_w;
    logic             out_w;

    rtc_outctl_reg #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR),
        .SECT_LO  (SECT_LO),
        .SECT_HI  (SECT_HI)
    ) u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ctl_o     (ctl)
    );

    rtc_outctl_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .wave_o (wave)
    );

    rtc_outctl_pinmux u_mux (
        .ctl_i      (ctl),
        .wave_i     (wave),
        .pull_low_o (pin_pull_low_o)
    );

    assign word = ctl_to_word(ctl);

    // Unused bit positions are tied to zero per bit.
    generate
        for (genvar b = 0; b < REG_W; b++) begin : g_rd
            if (LIVE[b]) begin : g_live
                assign rd_data_o[b] = (rd_addr_i == REG_A) && word[b];
            end else begin : g_zero
                assign rd_data_o[b] = 1'b0;
            end
        end
    endgenerate

    assign pwr_fail_o = ctl.pwr_fail;
    assign ft_w       = ctl.wave_en;
    assign out_w      = ctl.level;

endmodule

// File: rtl/rtc_outctl_chk.sv
module rtc_outctl_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 7,
    parameter int unsigned SECT_HI  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [7:0]        rd_data_o,
    input logic              pin_pull_low_o,
    input logic              pwr_fail_o,
    input logic              ft_w,
    input logic              out_w
);
    localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);
    localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(SECT_HI);

    logic seen_rst_q = 1'b0;
    always_ff @(posedge clk) seen_rst_q <= seen_rst_q | rst;

    AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (seen_rst_q && $past(rst)) |-> (pwr_fail_o && out_w && !ft_w && !pin_pull_low_o)); // R1

    AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_i != REG_A) |-> (rd_data_o == 8'h00)); // R2

    AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o[5:1] == 5'b0)); // R3

    AST_PF_NO_SET: assert property (@(posedge clk) disable iff (rst)
        !pwr_fail_o |=> !pwr_fail_o); // R4

    AST_PF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (wr_addr_i <= HI_A)) |=> !pwr_fail_o); // R5

    AST_PF_KEEP: assert property (@(posedge clk) disable iff (rst)
        (pwr_fail_o && !(wr_en_i && (wr_addr_i <= HI_A))) |=> pwr_fail_o); // R5

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && (wr_addr_i == REG_A)) |=> ($stable(ft_w) && $stable(out_w))); // R6

    AST_LEVEL_PIN: assert property (@(posedge clk) disable iff (rst)
        !ft_w |-> (pin_pull_low_o == !out_w)); // R7

    AST_WAVE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (seen_rst_q && !$past(rst) && ft_w && $past(ft_w) && !$past(tick_i)) |-> $stable(pin_pull_low_o)); // R8

endmodule

bind rtc_outctl rtc_outctl_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .SECT_HI  (SECT_HI)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .tick_i         (tick_i),
    .wr_en_i        (wr_en_i),
    .wr_addr_i      (wr_addr_i),
    .rd_addr_i      (rd_addr_i),
    .rd_data_o      (rd_data_o),
    .pin_pull_low_o (pin_pull_low_o),
    .pwr_fail_o     (pwr_fail_o),
    .ft_w           (ft_w),
    .out_w          (out_w)
);

// File: tb/rtc_outctl_bench.sv
module rtc_outctl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_addr_i = 8'h00;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_addr_i = 8'h07;
    logic [7:0] rd_data_o;
    logic       pin_pull_low_o;
    logic       pwr_fail_o;

    int checks = 0;
    int errors = 0;

    // Bench model
    bit m_out, m_ft, m_pf;
    int tick_cnt;

    always #5 clk = ~clk;

    rtc_outctl u_rtc_outctl (
        .clk            (clk),
        .rst            (rst),
        .tick_i         (tick_i),
        .wr_en_i        (wr_en_i),
        .wr_addr_i      (wr_addr_i),
        .wr_data_i      (wr_data_i),
        .rd_addr_i      (rd_addr_i),
        .rd_data_o      (rd_data_o),
        .pin_pull_low_o (pin_pull_low_o),
        .pwr_fail_o     (pwr_fail_o)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    function automatic bit exp_pull();
        if (m_ft) return ((tick_cnt % 64) < 32);
        return !m_out;
    endfunction

    function automatic logic [7:0] exp_word();
        return {m_out, m_ft, 5'b0, m_pf};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        if (a == 8'h07) begin m_out = d[7]; m_ft = d[6]; end
        if (a <= 8'h07) m_pf = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
            tick_cnt++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_out = 1'b1; m_ft = 1'b0; m_pf = 1'b1; tick_cnt = 0;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1; rd_addr_i = 8'h07;
        repeat (2) @(negedge clk);
        check("R1", "read during reset", rd_data_o, 8'h81);
        check("R1", "pin during reset", pin_pull_low_o, 0);
        rst = 1'b0;
        m_out = 1'b1; m_ft = 1'b0; m_pf = 1'b1; tick_cnt = 0;
        @(negedge clk);
        check("R1", "read after reset", rd_data_o, 8'h81);
        check("R1", "flag after reset", pwr_fail_o, 1);
        check("R1", "pin after reset", pin_pull_low_o, 0);
    endtask

    task automatic t_read_decode();
        for (int a = 0; a < 16; a++) begin
            if (a == 7) continue;
            rd_addr_i = 8'(a); #1;
            check("R2", "read other address", rd_data_o, 8'h00);
        end
        rd_addr_i = 8'hFF; #1;
        check("R2", "read 0xFF", rd_data_o, 8'h00);
        rd_addr_i = 8'h07; #1;
        check("R2", "read 07h", rd_data_o, exp_word());
    endtask

    task automatic t_pf_high_addr();
        wr(8'h08, 8'h00);
        check("R5", "flag after write 08h", pwr_fail_o, 1);
        wr(8'hFF, 8'hFF);
        check("R5", "flag after write FFh", pwr_fail_o, 1);
        check("R6", "fields untouched by FFh write", rd_data_o, 8'h81);
    endtask

    task automatic t_pf_clear_low();
        wr(8'h00, 8'h5A);
        check("R5", "flag after write 00h", pwr_fail_o, 0);
        check("R5", "read word after write 00h", rd_data_o, exp_word());
        check("R6", "fields untouched by 00h write", rd_data_o[7:6], 2'b10);
        do_reset();
        @(negedge clk);
        wr(8'h03, 8'h00);
        check("R5", "flag after write 03h", pwr_fail_o, 0);
        do_reset();
        @(negedge clk);
        wr(8'h07, 8'hBF);
        check("R5", "flag after write 07h", pwr_fail_o, 0);
        check("R3", "zero field after BFh write", rd_data_o, 8'h80);
    endtask

    task automatic t_pf_readonly();
        wr(8'h07, 8'hFF);
        check("R4", "flag after writing bit0=1", pwr_fail_o, 0);
        check("R3", "read after FFh write", rd_data_o, 8'hC0);
        wr(8'h07, 8'h01);
        check("R4", "flag bit in read word", rd_data_o[0], 0);
        check("R6", "level/enable loaded", rd_data_o[7:6], 2'b00);
    endtask

    task automatic t_level_pin();
        wr(8'h07, 8'h00);
        check("R7", "level 0 pulls low", pin_pull_low_o, 1);
        check("R6", "read level 0", rd_data_o, exp_word());
        ticks(40);
        check("R7", "level pin ignores ticks", pin_pull_low_o, 1);
        wr(8'h07, 8'h80);
        check("R7", "level 1 releases", pin_pull_low_o, 0);
        check("R6", "read level 1", rd_data_o, 8'h80);
    endtask

    task automatic t_wave();
        wr(8'h07, 8'h40);
        check("R8", "wave entry", pin_pull_low_o, exp_pull());
        for (int i = 0; i < 140; i++) begin
            ticks(1);
            check("R8", $sformatf("wave at tick %0d", tick_cnt), pin_pull_low_o, exp_pull());
        end
        // Level bit flipped while the wave runs: pin still follows the wave.
        wr(8'h07, 8'hC0);
        check("R8", "wave ignores level 1", pin_pull_low_o, exp_pull());
        for (int i = 0; i < 70; i++) begin
            ticks(1);
            check("R8", "wave with level 1", pin_pull_low_o, exp_pull());
        end
    endtask

    task automatic t_free_run();
        // Leave wave mode for a while; divider must keep counting.
        wr(8'h07, 8'h80);
        ticks(23);
        wr(8'h07, 8'h40);
        check("R9", "phase kept across disable", pin_pull_low_o, exp_pull());
        // Write coincident with a tick.
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 8'h07; wr_data_i = 8'h40;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0; tick_cnt++;
        check("R9", "tick counted during write", pin_pull_low_o, exp_pull());
        for (int i = 0; i < 70; i++) begin
            ticks(1);
            if (i % 8 == 0) wr(8'h02, 8'h00);
            check("R9", "phase across writes", pin_pull_low_o, exp_pull());
        end
    endtask

    initial begin
        t_reset();
        t_read_decode();
        t_pf_high_addr();
        t_pf_clear_low();
        t_pf_readonly();
        t_level_pin();
        t_wave();
        t_free_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule